// File: doc/BRIEF.md
# Interrupt Cause to Message Vector Router

The block gathers interrupt events from two 32-bit cause groups and from a set of receive queues, and steers each pending cause to one of up to sixteen message vectors. One cause group carries data-mover events (two device-to-host channels, one host-to-device channel and a mover error). The other carries general hardware events (alive, wakeup, thermal shutdown, radio switch, periodic tick, software error, scheduler, transmit, hardware error, host assist). Receive queue n raises bit n of the data-mover group. A one-byte routing entry per cause picks the vector and says whether the cause bit is cleared automatically when its message goes out.

Each vector is a small state machine with two states, VS_OPEN and VS_HELD. In VS_OPEN the vector raises a one-cycle message request as soon as a routed cause is pending and unmasked. The FIRE transition then takes it to VS_HELD, where it stays silent until software writes 1 to its auto-mask status bit. That write is the RELEASE transition back to VS_OPEN. Software reads and writes the cause, mask, status, control and routing registers through a plain 32-bit register port.

Top module: `irq_vector_router`

## Requirements
- R1: After reset, both mask registers read 0xFFFFFFFF. Both cause registers, the auto-mask status register, the control register and every routing entry read 0.
- R2: Register map, with byte addresses and combinational reads:
  - 0x000 mover causes; 0x004 mover mask; 0x008 hardware causes; 0x00C hardware mask; 0x010 auto-mask status, bit v for vector v; 0x014 control, bit 0 is the global enable.
  - Main routing entry i sits at 0x100+4*i. Mover bits 16, 17, 19, 21 use i = bit-16, so i = 0, 1, 3, 5. Hardware bits 0, 1, 6, 7, 8, 25, 26, 27, 29, 30 use i = bit+16, so i = 0x10 to 0x2E.
  - Receive entry n sits at 0x200+4*n.
  - An entry reads back bit 7 (non-auto-clear flag) and bits 3:0 (vector number); all other entry bits read 0.
  - Entries at unused indices read 0 and ignore writes.
- R3: An event pulse on an implemented cause bit sets that cause bit at the next clock edge. Events on unimplemented bits (for example hardware bit 2) never set anything.
- R4: Writing 1 to a cause bit clears it. An event arriving in the same cycle as that clear wins, and the bit stays 1.
- R5: A mask bit of 1 blocks its cause from every vector. Clearing the mask bit lets an already pending cause fire.
- R6: While control bit 0 is 0, no message request is raised, but causes are still recorded.
- R7: A pending, unmasked cause raises a one-cycle request on the vector named by bits 3:0 of its entry. The request appears in the cycle after the edge that records the cause, or after the edge that releases the vector.
- R8: FIRE sets the vector's auto-mask status bit, and no further request appears on that vector while the bit is set. Writing 1 to the bit (RELEASE) clears it, and the vector fires again at once if a routed cause is still pending.
- R9: If bit 7 of the entry is 0, the cause bit is cleared at the edge where its vector fires. If bit 7 is 1, the cause bit stays set until software clears it.
- R10: A receive event for queue n sets mover cause bit n and routes through receive entry n.
- R11: Vectors that become eligible in the same cycle all raise their requests in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fh_evt_i | input | 32 | Data-mover cause event pulses (bits 16, 17, 19, 21 used) |
| hw_evt_i | input | 32 | Hardware cause event pulses |
| rx_evt_i | input | NUM_RXQ | Receive queue event pulses |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| msg_req_o | output | NUM_VEC | One-cycle message request per vector |

## Verification
Cause and mask writes, cause captures and status releases are all visible on the read port right after the clock edge that applies them. A message request is due combinationally in the cycle after the edge that records the cause, sets the enable or clears the mask, or releases the vector. Automatic cause clearing and the status bit set by FIRE are due one edge later. The bench drives every input at a falling edge and samples at the next falling edge, so each check lands half a cycle after the edge its result depends on.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

    localparam int CAUSE_W = 32;
    localparam int ADDR_W  = 12;
    localparam int NAC_BIT = 7;

    localparam logic [CAUSE_W-1:0] FH_FIXED = 32'h002B_0000;
    localparam logic [CAUSE_W-1:0] HW_IMPL  = 32'h6E00_01C3;

    localparam logic [ADDR_W-1:0] A_FH_CAUSE = 12'h000;
    localparam logic [ADDR_W-1:0] A_FH_MASK  = 12'h004;
    localparam logic [ADDR_W-1:0] A_HW_CAUSE = 12'h008;
    localparam logic [ADDR_W-1:0] A_HW_MASK  = 12'h00C;
    localparam logic [ADDR_W-1:0] A_AMASK    = 12'h010;
    localparam logic [ADDR_W-1:0] A_CTRL     = 12'h014;
    localparam int               MAIN_BASE  = 'h100;
    localparam int               RX_BASE    = 'h200;

    typedef enum logic {
        VS_OPEN = 1'b0,
        VS_HELD = 1'b1
    } vec_state_e;

    function automatic logic [ADDR_W-1:0] fh_ent_addr(input int b, input int nrx);
        if (b < nrx) return ADDR_W'(RX_BASE + 4 * b);
        return ADDR_W'(MAIN_BASE + 4 * (b - 16));
    endfunction

    function automatic logic [ADDR_W-1:0] hw_ent_addr(input int b);
        return ADDR_W'(MAIN_BASE + 4 * (b + 16));
    endfunction

endpackage

// File: rtl/ivr_vec_fsm.sv
module ivr_vec_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic elig_i,
    input  logic release_i,
    output logic req_o,
    output logic held_o
);
    import ivr_pkg::*;

    vec_state_e state_q;
    vec_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VS_OPEN: if (elig_i)    state_d = VS_HELD;
            VS_HELD: if (release_i) state_d = VS_OPEN;
            default: state_d = VS_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= VS_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        req_o  = 1'b0;
        held_o = 1'b0;
        unique case (state_q)
            VS_OPEN: req_o  = elig_i;
            VS_HELD: held_o = 1'b1;
            default: req_o  = 1'b0;
        endcase
    end

    // R8: a held vector stays held until software releases it
    a_r8_held_until_release: assert property (@(posedge clk) disable iff (!rst_n)
        (held_o && !release_i) |=> held_o);

endmodule

// File: rtl/ivr_route.sv
module ivr_route #(
    parameter int NUM_VEC = 16,
    parameter int VEC_W   = 4,
    parameter int ENT_W   = VEC_W + 1
) (
    input  logic [31:0]            fh_cause_i,
    input  logic [31:0]            fh_mask_i,
    input  logic [31:0]            hw_cause_i,
    input  logic [31:0]            hw_mask_i,
    input  logic                   en_i,
    input  logic [31:0][ENT_W-1:0] fh_ent_i,
    input  logic [31:0][ENT_W-1:0] hw_ent_i,
    input  logic [NUM_VEC-1:0]     fire_i,
    output logic [NUM_VEC-1:0]     elig_o,
    output logic [31:0]            fh_aclr_o,
    output logic [31:0]            hw_aclr_o
);
    localparam int SLOTS = 1 << VEC_W;

    logic [SLOTS-1:0] elig_all;
    logic [SLOTS-1:0] fire_all;

    assign fire_all = SLOTS'(fire_i);

    always_comb begin
        elig_all  = '0;
        fh_aclr_o = '0;
        hw_aclr_o = '0;
        for (int b = 0; b < 32; b++) begin
            logic fa;
            logic ha;
            logic [VEC_W-1:0] fv;
            logic [VEC_W-1:0] hv;
            fa = fh_cause_i[b] & ~fh_mask_i[b] & en_i;
            ha = hw_cause_i[b] & ~hw_mask_i[b] & en_i;
            fv = fh_ent_i[b][VEC_W-1:0];
            hv = hw_ent_i[b][VEC_W-1:0];
            if (fa) elig_all[fv] = 1'b1;
            if (ha) elig_all[hv] = 1'b1;
            fh_aclr_o[b] = fa & ~fh_ent_i[b][VEC_W] & fire_all[fv];
            hw_aclr_o[b] = ha & ~hw_ent_i[b][VEC_W] & fire_all[hv];
        end
    end

    assign elig_o = elig_all[NUM_VEC-1:0];

endmodule

// File: rtl/ivr_regs.sv
module ivr_regs #(
    parameter int NUM_VEC = 16,
    parameter int NUM_RXQ = 15,
    parameter int VEC_W   = 4,
    parameter int ENT_W   = VEC_W + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [31:0]            fh_evt_i,
    input  logic [31:0]            hw_evt_i,
    input  logic [NUM_RXQ-1:0]     rx_evt_i,
    input  logic                   reg_we_i,
    input  logic [11:0]            reg_addr_i,
    input  logic [31:0]            reg_wdata_i,
    output logic [31:0]            reg_rdata_o,
    input  logic [NUM_VEC-1:0]     amask_i,
    output logic [NUM_VEC-1:0]     amask_clr_o,
    input  logic [31:0]            fh_aclr_i,
    input  logic [31:0]            hw_aclr_i,
    output logic [31:0]            fh_cause_o,
    output logic [31:0]            fh_mask_o,
    output logic [31:0]            hw_cause_o,
    output logic [31:0]            hw_mask_o,
    output logic                   en_o,
    output logic [31:0][ENT_W-1:0] fh_ent_o,
    output logic [31:0][ENT_W-1:0] hw_ent_o
);
    import ivr_pkg::*;

    localparam logic [31:0] RXQ_BITS = 32'((64'd1 << NUM_RXQ) - 64'd1);
    localparam logic [31:0] FH_IMPL  = FH_FIXED | RXQ_BITS;

    logic [31:0] fh_cause_q, hw_cause_q, fh_mask_q, hw_mask_q;
    logic        en_q;
    logic [31:0] fh_w1c, hw_w1c, fh_set, hw_set;
    logic [ENT_W-1:0] ent_wval;

    assign fh_w1c   = (reg_we_i && reg_addr_i == A_FH_CAUSE) ? reg_wdata_i : '0;
    assign hw_w1c   = (reg_we_i && reg_addr_i == A_HW_CAUSE) ? reg_wdata_i : '0;
    assign fh_set   = ((fh_evt_i & FH_FIXED) | 32'(rx_evt_i)) & FH_IMPL;
    assign hw_set   = hw_evt_i & HW_IMPL;
    assign ent_wval = {reg_wdata_i[NAC_BIT], reg_wdata_i[VEC_W-1:0]};
    assign amask_clr_o = (reg_we_i && reg_addr_i == A_AMASK) ?
                         reg_wdata_i[NUM_VEC-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fh_cause_q <= '0;
            hw_cause_q <= '0;
            fh_mask_q  <= '1;
            hw_mask_q  <= '1;
            en_q       <= 1'b0;
        end else begin
            fh_cause_q <= (fh_cause_q & ~fh_w1c & ~fh_aclr_i) | fh_set;
            hw_cause_q <= (hw_cause_q & ~hw_w1c & ~hw_aclr_i) | hw_set;
            if (reg_we_i && reg_addr_i == A_FH_MASK) fh_mask_q <= reg_wdata_i;
            if (reg_we_i && reg_addr_i == A_HW_MASK) hw_mask_q <= reg_wdata_i;
            if (reg_we_i && reg_addr_i == A_CTRL)    en_q      <= reg_wdata_i[0];
        end
    end

    for (genvar b = 0; b < 32; b++) begin : g_ent
        if (FH_IMPL[b]) begin : g_fh
            localparam logic [11:0] WA = fh_ent_addr(b, NUM_RXQ);
            logic [ENT_W-1:0] e_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                             e_q <= '0;
                else if (reg_we_i && reg_addr_i == WA)  e_q <= ent_wval;
            end
            assign fh_ent_o[b] = e_q;
        end else begin : g_fh_none
            assign fh_ent_o[b] = '0;
        end
        if (HW_IMPL[b]) begin : g_hw
            localparam logic [11:0] WA = hw_ent_addr(b);
            logic [ENT_W-1:0] e_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                             e_q <= '0;
                else if (reg_we_i && reg_addr_i == WA)  e_q <= ent_wval;
            end
            assign hw_ent_o[b] = e_q;
        end else begin : g_hw_none
            assign hw_ent_o[b] = '0;
        end
    end

    function automatic logic [31:0] fmt_ent(input logic [ENT_W-1:0] e);
        logic [31:0] r;
        r = 32'(e[VEC_W-1:0]);
        r[NAC_BIT] = e[VEC_W];
        return r;
    endfunction

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            A_FH_CAUSE: reg_rdata_o = fh_cause_q;
            A_FH_MASK:  reg_rdata_o = fh_mask_q;
            A_HW_CAUSE: reg_rdata_o = hw_cause_q;
            A_HW_MASK:  reg_rdata_o = hw_mask_q;
            A_AMASK:    reg_rdata_o = 32'(amask_i);
            A_CTRL:     reg_rdata_o = {31'b0, en_q};
            default:    reg_rdata_o = '0;
        endcase
        for (int b = 0; b < 32; b++) begin
            if (FH_IMPL[b] && reg_addr_i == fh_ent_addr(b, NUM_RXQ))
                reg_rdata_o = fmt_ent(fh_ent_o[b]);
            if (HW_IMPL[b] && reg_addr_i == hw_ent_addr(b))
                reg_rdata_o = fmt_ent(hw_ent_o[b]);
        end
    end

    assign fh_cause_o = fh_cause_q;
    assign hw_cause_o = hw_cause_q;
    assign fh_mask_o  = fh_mask_q;
    assign hw_mask_o  = hw_mask_q;
    assign en_o       = en_q;

    // R3, R4: a recorded event is present after the edge, even against a clear
    a_r3_event_captured: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != 0) |=> ((hw_cause_q & $past(hw_set)) == $past(hw_set)));

    a_r4_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (fh_set != 0) |=> ((fh_cause_q & $past(fh_set)) == $past(fh_set)));

endmodule

// File: rtl/irq_vector_router.sv
module irq_vector_router #(
    parameter int NUM_VEC = 16,
    parameter int NUM_RXQ = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [31:0]        fh_evt_i,
    input  logic [31:0]        hw_evt_i,
    input  logic [NUM_RXQ-1:0] rx_evt_i,
    input  logic               reg_we_i,
    input  logic [11:0]        reg_addr_i,
    input  logic [31:0]        reg_wdata_i,
    output logic [31:0]        reg_rdata_o,
    output logic [NUM_VEC-1:0] msg_req_o
);
    localparam int VEC_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
    localparam int ENT_W = VEC_W + 1;

    logic [31:0]            fh_cause, fh_mask, hw_cause, hw_mask;
    logic [31:0]            fh_aclr, hw_aclr;
    logic                   en;
    logic [31:0][ENT_W-1:0] fh_ent, hw_ent;
    logic [NUM_VEC-1:0]     elig, amask, amask_clr, fire;

    ivr_regs #(.NUM_VEC(NUM_VEC), .NUM_RXQ(NUM_RXQ), .VEC_W(VEC_W), .ENT_W(ENT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .fh_evt_i    (fh_evt_i),
        .hw_evt_i    (hw_evt_i),
        .rx_evt_i    (rx_evt_i),
        .reg_we_i    (reg_we_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .amask_i     (amask),
        .amask_clr_o (amask_clr),
        .fh_aclr_i   (fh_aclr),
        .hw_aclr_i   (hw_aclr),
        .fh_cause_o  (fh_cause),
        .fh_mask_o   (fh_mask),
        .hw_cause_o  (hw_cause),
        .hw_mask_o   (hw_mask),
        .en_o        (en),
        .fh_ent_o    (fh_ent),
        .hw_ent_o    (hw_ent)
    );

    ivr_route #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .ENT_W(ENT_W)) u_route (
        .fh_cause_i (fh_cause),
        .fh_mask_i  (fh_mask),
        .hw_cause_i (hw_cause),
        .hw_mask_i  (hw_mask),
        .en_i       (en),
        .fh_ent_i   (fh_ent),
        .hw_ent_i   (hw_ent),
        .fire_i     (fire),
        .elig_o     (elig),
        .fh_aclr_o  (fh_aclr),
        .hw_aclr_o  (hw_aclr)
    );

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        ivr_vec_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .elig_i    (elig[v]),
            .release_i (amask_clr[v]),
            .req_o     (fire[v]),
            .held_o    (amask[v])
        );

        // R8: every request is followed by the vector's status bit
        a_r8_fire_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
            msg_req_o[v] |=> amask[v]);
    end

    assign msg_req_o = fire;

    // R6: no request while the global enable is off
    a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (msg_req_o == '0));

    // R7: a request is only one cycle long
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_req_o != '0) |=> ((msg_req_o & $past(msg_req_o)) == '0));

endmodule

// File: tb/tb_irq_vector_router.sv
module tb_irq_vector_router;

    localparam int NV = 16;
    localparam int NR = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   fh_evt = '0;
    logic [31:0]   hw_evt = '0;
    logic [NR-1:0] rx_evt = '0;
    logic          we = 1'b0;
    logic [11:0]   addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NV-1:0] req;

    int total = 0;
    int bad = 0;
    bit done = 0;

    irq_vector_router #(.NUM_VEC(NV), .NUM_RXQ(NR)) dut (
        .clk (clk), .rst_n (rst_n), .fh_evt_i (fh_evt), .hw_evt_i (hw_evt),
        .rx_evt_i (rx_evt), .reg_we_i (we), .reg_addr_i (addr),
        .reg_wdata_i (wdata), .reg_rdata_o (rdata), .msg_req_o (req)
    );

    always #10 clk = ~clk;

    localparam logic [11:0] FHC = 12'h000, FHM = 12'h004, HWC = 12'h008;
    localparam logic [11:0] HWM = 12'h00C, AMS = 12'h010, CTL = 12'h014;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse(input logic [31:0] f, input logic [31:0] h, input logic [NR-1:0] r);
        @(negedge clk);
        fh_evt = f; hw_evt = h; rx_evt = r;
        @(negedge clk);
        fh_evt = '0; hw_evt = '0; rx_evt = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(FHM, d); chk("R1 fh mask", d, 32'hFFFF_FFFF);
        rd(HWM, d); chk("R1 hw mask", d, 32'hFFFF_FFFF);
        rd(FHC, d); chk("R1 fh cause", d, 0);
        rd(HWC, d); chk("R1 hw cause", d, 0);
        rd(AMS, d); chk("R1 status", d, 0);
        rd(CTL, d); chk("R1 ctrl", d, 0);
        rd(12'h140, d); chk("R1 entry", d, 0);
        chk("R1 req", 32'(req), 0);
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        wr(HWM, ~32'h1);
        rd(HWM, d); chk("R2 mask readback", d, ~32'h1);
        pulse(0, 32'h1, 0);
        chk("R6 no req when off", 32'(req), 0);
        rd(HWC, d); chk("R3 cause captured", d, 32'h1);
        step();
        chk("R6 still quiet", 32'(req), 0);
        @(negedge clk);
        we = 1'b1; addr = HWC; wdata = 32'h1; hw_evt = 32'h1;
        @(negedge clk);
        we = 1'b0; hw_evt = '0;
        rd(HWC, d); chk("R4 event wins over clear", d, 32'h1);
        wr(HWC, 32'h1);
        rd(HWC, d); chk("R4 w1c clears", d, 0);
    endtask

    task automatic t_unused();
        logic [31:0] d;
        pulse(0, 32'h4, 0);
        rd(HWC, d); chk("R3 unimplemented bit", d, 0);
        wr(12'h108, 32'h85);
        rd(12'h108, d); chk("R2 unused entry", d, 0);
        wr(12'h140, 32'hF5);
        rd(12'h140, d); chk("R2 entry format", d, 32'h85);
    endtask

    task automatic t_route_hold();
        logic [31:0] d;
        wr(CTL, 32'h1);
        pulse(0, 32'h1, 0);
        chk("R7 route to vector 5", 32'(req), 32'h20);
        step();
        chk("R7 one cycle", 32'(req), 0);
        rd(AMS, d); chk("R8 status set", d, 32'h20);
        rd(HWC, d); chk("R9 non-auto-clear kept", d, 32'h1);
        pulse(0, 32'h1, 0);
        chk("R8 held vector quiet", 32'(req), 0);
        wr(AMS, 32'h20);
        chk("R8 refire after release", 32'(req), 32'h20);
        step();
        wr(HWC, 32'h1);
        wr(AMS, 32'h20);
        rd(AMS, d); chk("R8 release clears", d, 0);
        chk("R8 nothing pending", 32'(req), 0);
    endtask

    task automatic t_autoclear();
        logic [31:0] d;
        wr(12'h10C, 32'h02);
        wr(FHM, ~(32'h1 << 19));
        pulse(32'h1 << 19, 0, 0);
        chk("R7 mover cause to vector 2", 32'(req), 32'h4);
        rd(FHC, d); chk("R3 mover cause set", d, 32'h1 << 19);
        step();
        rd(FHC, d); chk("R9 auto-clear", d, 0);
        rd(AMS, d); chk("R8 status vec2", d, 32'h4);
        wr(AMS, 32'h4);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(12'h15C, 32'h83);
        pulse(0, 32'h80, 0);
        chk("R5 masked cause blocked", 32'(req), 0);
        rd(HWC, d); chk("R5 cause still recorded", d, 32'h80);
        wr(HWM, ~32'h81);
        chk("R5 unmask fires", 32'(req), 32'h8);
        step();
        wr(HWC, 32'h80);
        wr(AMS, 32'h8);
    endtask

    task automatic t_rx();
        logic [31:0] d;
        wr(12'h210, 32'h07);
        wr(FHM, ~((32'h1 << 19) | 32'h10));
        pulse(0, 0, NR'(16'h10));
        chk("R10 queue 4 to vector 7", 32'(req), 32'h80);
        rd(FHC, d); chk("R10 queue bit set", d, 32'h10);
        step();
        rd(FHC, d); chk("R10 queue auto-cleared", d, 0);
        wr(AMS, 32'h80);
    endtask

    task automatic t_multi();
        logic [31:0] d;
        wr(12'h144, 32'h89);
        wr(12'h114, 32'h8C);
        wr(HWM, ~32'h83);
        wr(FHM, ~((32'h1 << 19) | 32'h10 | (32'h1 << 21)));
        pulse(32'h1 << 21, 32'h2, 0);
        chk("R11 two vectors together", 32'(req), 32'h1200);
        step();
        rd(AMS, d); chk("R11 both held", d, 32'h1200);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=%h exp=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_disabled();
        t_unused();
        t_route_hold();
        t_autoclear();
        t_mask();
        t_rx();
        t_multi();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule